// File: doc/BRIEF.md
# Serial Page-Size Configuration Unit

This block is the command front end of a serial memory that owns one one-time-programmable configuration bit. That bit selects the page size. It watches a mode-0 SPI slave port, with data sampled on the rising clock edge and changed on the falling edge. The port's pins are sampled into the system clock domain through synchronizer chains.

The page-size bit can only be set by a four-byte unlock command. The command commits only when chip select is released right after the 32nd bit. Commit starts a self-timed program cycle, and the status byte shows the unit busy for its duration. When the cycle ends, the bit is set for good.

The active page size seen by the rest of the memory is loaded only on a power cycle, which the `pwrCycle` input models. A power cycle that lands during programming cancels the cycle and leaves the bit clear, so the command can be sent again. A status-read opcode returns the status byte on the SPI output.

Top module: `pgsize_cfg_unit`

## Requirements
- R1: After reset `pageBytes` is 528, the status byte reads 0x00, and `pageBytes` only ever holds 528 or 512.
- R2: The bytes 3DH, 2AH, 80H, A6H are sent MSB first under one chip-select low period, and chip select then rises with exactly 32 bits clocked. This starts a program cycle of PROG_CYCLES system clocks, during which status bit 7 is 1. At its end bit 7 returns to 0 and status bit 0 becomes 1 in the same cycle.
- R3: A sequence with any byte differing from the unlock order starts no program cycle.
- R4: Chip select rising before all 32 bits (fewer bytes, or a partial last byte) starts no program cycle.
- R5: Chip select rising after more than 32 bits (an extra bit or an extra byte) starts no program cycle.
- R6: Opcode D7H as the first byte makes the unit shift out the status byte MSB first. Each bit changes on a falling SCK edge, the first on the fall that follows the opcode. Bit 7 is busy, bit 0 is the programmed flag, and bits 6..1 are 0.
- R7: Completing the program cycle does not change `pageBytes`. The next `pwrCycle` pulse makes it 512, and `pageBytes` changes only in the cycle after a `pwrCycle` pulse.
- R8: A `pwrCycle` pulse during the program cycle ends busy, leaves bit 0 clear and `pageBytes` at 528. The unlock command can then be reissued and succeeds.
- R9: An unlock command received while busy is ignored and does not restart or extend the running cycle.
- R10: Once bit 0 is set it never clears. A later unlock command starts no cycle, and `pageBytes` stays 512 across power cycles.
- R11: `spiMiso` is 0 whenever `spiCsN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; initial unprogrammed state |
| pwrCycle | input | 1 | One-cycle pulse modelling a power-down/power-up |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSck | input | 1 | SPI clock (mode 0) |
| spiMosi | input | 1 | SPI serial data in |
| spiMiso | output | 1 | SPI serial data out |
| pageBytes | output | 10 | Active page size in bytes (528 or 512) |

## Verification
The bench attacks the commit condition from every side: a wrong third byte, three bytes, 31 bits, 33 bits and five bytes. A unit that counted bytes loosely or committed on the last byte instead of on chip-select release would go busy on one of these. It cuts a program cycle with a power cycle and then reissues the command, which catches a design that sets the bit early or locks up after an abort. A second unlock sent mid-cycle is followed by a status read timed after the first cycle's end. A design that restarts its timer would still read busy there. Finally it checks that the page size moves only on a power cycle and never reverts, and that both status patterns 0x80 and 0x01 come out in MSB-first order.

// File: rtl/pgsize_cfg_pkg.sv
package pgsize_cfg_pkg;

  localparam int BYTE_W  = 8;
  localparam int SEQ_LEN = 4;
  localparam int PAGE_W  = 10;

  localparam logic [BYTE_W-1:0] OP_STATUS = 8'hD7;
  localparam logic [PAGE_W-1:0] PAGE_STD  = 10'd528;
  localparam logic [PAGE_W-1:0] PAGE_BIN  = 10'd512;

  // Strobes from control towards the datapath
  typedef struct packed {
    logic armStatus;  // status opcode seen: start serving status on next SCK fall
    logic dropTx;     // abandon any transmit in progress
  } ctlStrobes_t;

  // Events from the datapath towards control
  typedef struct packed {
    logic              csFall;
    logic              csRise;
    logic              byteDone;
    logic              partial;   // bits of an unfinished byte are pending
    logic [BYTE_W-1:0] byteVal;
  } spiEvents_t;

  // Expected unlock byte by position; the order is behaviour
  function automatic logic [BYTE_W-1:0] unlockByte(input logic [1:0] idx);
    case (idx)
      2'd0:    unlockByte = 8'h3D;
      2'd1:    unlockByte = 8'h2A;
      2'd2:    unlockByte = 8'h80;
      default: unlockByte = 8'hA6;
    endcase
  endfunction

endpackage

// File: rtl/pgsize_cfg_datapath.sv
module pgsize_cfg_datapath
  import pgsize_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  input  ctlStrobes_t       strobes,
  input  logic [BYTE_W-1:0] statusByte,
  output spiEvents_t        events,
  output logic              spiMiso
);

  localparam int NUM_SYNC = 3;
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 3'b100;  // chip select idles high

  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] syncOut;

  assign rawIn = {spiCsN, spiSck, spiMosi};

  genvar g;
  generate
    for (g = 0; g < NUM_SYNC; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {SYNC_STAGES{SYNC_RST[g]}};
        else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
      end
      assign syncOut[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic csS, sckS, mosiS;
  logic csPrev, sckPrev;
  assign csS   = syncOut[2];
  assign sckS  = syncOut[1];
  assign mosiS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  logic sckRise, sckFall, csFallE, csRiseE;
  assign sckRise = sckS & ~sckPrev & ~csS;
  assign sckFall = ~sckS & sckPrev & ~csS;
  assign csFallE = ~csS & csPrev;
  assign csRiseE = csS & ~csPrev;

  // Receive shifter
  logic [BYTE_W-1:0] shiftIn;
  logic [BIT_W-1:0]  bitCnt;
  logic              byteDoneQ;
  logic [BYTE_W-1:0] byteValQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn   <= '0;
      bitCnt    <= '0;
      byteDoneQ <= 1'b0;
      byteValQ  <= '0;
    end else begin
      byteDoneQ <= 1'b0;
      if (csFallE) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        shiftIn <= {shiftIn[BYTE_W-2:0], mosiS};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == BIT_W'(BYTE_W - 1)) begin
          byteDoneQ <= 1'b1;
          byteValQ  <= {shiftIn[BYTE_W-2:0], mosiS};
        end
      end
    end
  end

  // Transmit shifter: loads on the first fall after arming, then rotates
  logic              txPending, txOn;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPending <= 1'b0;
      txOn      <= 1'b0;
      txShift   <= '0;
    end else if (csS || strobes.dropTx) begin
      txPending <= 1'b0;
      txOn      <= 1'b0;
    end else if (strobes.armStatus) begin
      txPending <= 1'b1;
    end else if (sckFall) begin
      if (txPending) begin
        txShift   <= statusByte;
        txOn      <= 1'b1;
        txPending <= 1'b0;
      end else if (txOn) begin
        txShift <= {txShift[BYTE_W-2:0], txShift[BYTE_W-1]};
      end
    end
  end

  assign spiMiso = ~spiCsN & txOn & txShift[BYTE_W-1];

  assign events.csFall   = csFallE;
  assign events.csRise   = csRiseE;
  assign events.byteDone = byteDoneQ;
  assign events.partial  = (bitCnt != '0);
  assign events.byteVal  = byteValQ;

endmodule

// File: rtl/pgsize_cfg_control.sv
module pgsize_cfg_control
  import pgsize_cfg_pkg::*;
#(
  parameter int PROG_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrCycle,
  input  spiEvents_t        events,
  output ctlStrobes_t       strobes,
  output logic [BYTE_W-1:0] statusByte,
  output logic [PAGE_W-1:0] pageBytes
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int IDX_W = $clog2(SEQ_LEN + 1);

  typedef enum logic {CFG_IDLE, CFG_PROG} cfgState_e;

  cfgState_e         state;
  logic [CNT_W-1:0]  progCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic              seqOk;
  logic              otpSet;
  logic [PAGE_W-1:0] pageQ;
  logic              commit;

  // Unlock sequence tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      seqOk   <= 1'b0;
    end else if (events.csFall) begin
      byteIdx <= '0;
      seqOk   <= 1'b1;
    end else if (events.byteDone) begin
      if (byteIdx < IDX_W'(SEQ_LEN)) begin
        if (events.byteVal != unlockByte(byteIdx[1:0])) seqOk <= 1'b0;
        byteIdx <= byteIdx + 1'b1;
      end else begin
        seqOk <= 1'b0;  // bytes beyond the fourth
      end
    end
  end

  assign commit = events.csRise && seqOk && (byteIdx == IDX_W'(SEQ_LEN))
                  && !events.partial && (state == CFG_IDLE) && !otpSet;

  // Self-timed program cycle and the one-time bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CFG_IDLE;
      progCnt <= '0;
      otpSet  <= 1'b0;
    end else if (pwrCycle) begin
      state   <= CFG_IDLE;
      progCnt <= '0;
    end else begin
      case (state)
        CFG_IDLE: if (commit) begin
          state   <= CFG_PROG;
          progCnt <= CNT_W'(PROG_CYCLES - 1);
        end
        CFG_PROG: if (progCnt == '0) begin
          state  <= CFG_IDLE;
          otpSet <= 1'b1;
        end else begin
          progCnt <= progCnt - 1'b1;
        end
        default: state <= CFG_IDLE;
      endcase
    end
  end

  // Active page size is sampled from the bit only at power-up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pageQ <= PAGE_STD;
    else if (pwrCycle) pageQ <= otpSet ? PAGE_BIN : PAGE_STD;
  end

  assign pageBytes  = pageQ;
  assign statusByte = {state == CFG_PROG, {(BYTE_W-2){1'b0}}, otpSet};

  assign strobes.armStatus = events.byteDone && (byteIdx == '0)
                             && (events.byteVal == OP_STATUS);
  assign strobes.dropTx    = pwrCycle;

endmodule

// File: rtl/pgsize_cfg_unit.sv
module pgsize_cfg_unit
  import pgsize_cfg_pkg::*;
#(
  parameter int PROG_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrCycle,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [PAGE_W-1:0] pageBytes
);

  ctlStrobes_t       strobes;
  spiEvents_t        events;
  logic [BYTE_W-1:0] statusByte;

  pgsize_cfg_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .spiCsN     (spiCsN),
    .spiSck     (spiSck),
    .spiMosi    (spiMosi),
    .strobes    (strobes),
    .statusByte (statusByte),
    .events     (events),
    .spiMiso    (spiMiso)
  );

  pgsize_cfg_control #(.PROG_CYCLES(PROG_CYCLES)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .pwrCycle   (pwrCycle),
    .events     (events),
    .strobes    (strobes),
    .statusByte (statusByte),
    .pageBytes  (pageBytes)
  );

endmodule

// File: rtl/pgsize_cfg_checker.sv
module pgsize_cfg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pwrCycle,
  input logic       spiCsN,
  input logic       spiMiso,
  input logic [7:0] statusByte,
  input logic [9:0] pageBytes
);

  p_page_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pageBytes == 10'd528) || (pageBytes == 10'd512));

  p_done_sets_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(statusByte[7]) && !$past(pwrCycle)) |-> statusByte[0]);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:1] == 6'b0);

  p_page_on_pwr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pageBytes) |-> $past(pwrCycle));

  p_pwr_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    pwrCycle |=> !statusByte[7]);

  p_bit_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |=> statusByte[0]);

  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiMiso);

endmodule

bind pgsize_cfg_unit pgsize_cfg_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .pwrCycle   (pwrCycle),
  .spiCsN     (spiCsN),
  .spiMiso    (spiMiso),
  .statusByte (statusByte),
  .pageBytes  (pageBytes)
);

// File: tb/test_pgsize_cfg_unit.sv
`timescale 1ns/1ps
module test_pgsize_cfg_unit;

  localparam int PROG = 1000;
  localparam int HALF = 6;   // system clocks per SCK half period

  typedef struct {
    string       tag;
    logic [15:0] val;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrCycle = 1'b0;
  logic       spiCsN = 1'b1;
  logic       spiSck = 1'b0;
  logic       spiMosi = 1'b0;
  logic       spiMiso;
  logic [9:0] pageBytes;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  item_t expQ[$];
  item_t actQ[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pgsize_cfg_unit #(.PROG_CYCLES(PROG)) i_pgsize_cfg_unit (
    .clk(clk), .rstN(rstN), .pwrCycle(pwrCycle),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .pageBytes(pageBytes)
  );

  // Monitor: compares produced results with expectations in order
  initial begin
    forever begin
      wait (actQ.size() != 0);
      begin
        item_t a, e;
        a = actQ.pop_front();
        e = expQ.pop_front();
        nChecks++;
        if (a.val !== e.val) begin
          nFail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a.val, e.val);
        end
      end
    end
  end

  task automatic expect_item(input string tag, input logic [15:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    expQ.push_back(it);
  endtask

  task automatic produce(input string tag, input logic [15:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    actQ.push_back(it);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spiMosi = b[i];
      waitClk(HALF);
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  task automatic sendUnlock(input logic [7:0] b2, input int nBytes, input int tailBits);
    logic [7:0] seq [4];
    seq[0] = 8'h3D; seq[1] = 8'h2A; seq[2] = b2; seq[3] = 8'hA6;
    csLow();
    for (int k = 0; k < nBytes; k++) sendBits(seq[k % 4], 8);
    if (tailBits > 0) sendBits(seq[nBytes % 4], tailBits);
    csHigh();
  endtask

  task automatic readStatus(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    expect_item(tag, {8'h00, exp});
    csLow();
    sendBits(8'hD7, 8);
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      got[i] = spiMiso;
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
    csHigh();
    produce(tag, {8'h00, got});
  endtask

  task automatic checkPage(input string tag, input logic [9:0] exp);
    expect_item(tag, {6'd0, exp});
    produce(tag, {6'd0, pageBytes});
  endtask

  task automatic pulsePwr();
    pwrCycle = 1'b1;
    waitClk(1);
    pwrCycle = 1'b0;
    waitClk(4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1: reset state
    checkPage("R1 reset page", 10'd528);
    readStatus("R1 reset status", 8'h00);

    // R11: MISO quiet while deselected, even with SCK toggling
    sendBits(8'hFF, 4);
    expect_item("R11 miso idle", 16'h0);
    produce("R11 miso idle", {15'd0, spiMiso});

    // R3: wrong third byte
    sendUnlock(8'h81, 4, 0);
    readStatus("R3 wrong byte", 8'h00);

    // R4: three bytes, then 31 bits
    sendUnlock(8'h80, 3, 0);
    readStatus("R4 three bytes", 8'h00);
    sendUnlock(8'h80, 3, 7);
    readStatus("R4 31 bits", 8'h00);

    // R5: 33 bits, then five bytes
    sendUnlock(8'h80, 4, 1);
    readStatus("R5 33 bits", 8'h00);
    sendUnlock(8'h80, 5, 0);
    readStatus("R5 five bytes", 8'h00);

    // R2/R6: valid sequence starts busy (0x80, MSB first)
    sendUnlock(8'h80, 4, 0);
    readStatus("R2 busy after commit", 8'h80);

    // R8: power cycle aborts programming
    pulsePwr();
    readStatus("R8 abort status", 8'h00);
    checkPage("R8 abort page", 10'd528);

    // R8/R9: reissue, then resend while busy
    sendUnlock(8'h80, 4, 0);
    t0 = cyc;
    readStatus("R8 reissue busy", 8'h80);
    waitClk(100);
    sendUnlock(8'h80, 4, 0);
    readStatus("R9 still busy", 8'h80);
    while (cyc < t0 + PROG + 150) waitClk(1);
    readStatus("R9 no restart / R2 done", 8'h01);

    // R7: page changes only on the power cycle
    checkPage("R7 before pwr", 10'd528);
    pulsePwr();
    checkPage("R7 after pwr", 10'd512);
    readStatus("R7 status kept", 8'h01);

    // R10: no re-programming and no revert
    sendUnlock(8'h80, 4, 0);
    readStatus("R10 no new cycle", 8'h01);
    pulsePwr();
    checkPage("R10 page stays", 10'd512);
    readStatus("R10 bit stays", 8'h01);

    wait (actQ.size() == 0);
    waitClk(2);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule